// File: doc/BRIEF.md
# Bus-Master Tenure Timer

This block limits how long a bus master may keep the shared bus once it has started a transaction. Software programs an 8-bit tenure limit. Only the upper four bits of that limit can be written. The lower four bits are fixed at ones, so the limit moves in steps of 16 clocks.

When the master starts a transaction (the cycle in which it asserts FRAME#), the timer loads the limit. It then counts down by one on every bus clock while the master owns the bus, and it stops at zero. The grant input is active low.

Expiry alone never ends a burst. The block raises a must-release indication only when the count has reached zero and the arbiter has also taken the grant away. The master sequencer uses that indication to close its burst at the next data phase. A completed transfer ends the tenure early, whatever the count.

Top module: `mst_tenure_timer`

## Requirements
- R1: Bits [3:0] of `cfgLimit` read 4'b1111 at all times, whatever was written to them. After reset, `cfgLimit` is 8'h0F.
- R2: A cycle with `cfgWrEn` high copies `cfgWrData[7:4]` into `cfgLimit[7:4]`, visible from the next cycle. Without `cfgWrEn` the field keeps its value.
- R3: A cycle with `frameStart` high loads `tenureCount` with `cfgLimit` and sets `busOwned`, both visible from the next cycle.
- R4: While `busOwned` is high and `tenureCount` is nonzero, `tenureCount` falls by exactly one per clock, so it reaches zero L clocks after the load of limit L.
- R5: Once `tenureCount` reaches zero during a tenure, it stays at zero. `expired` is high exactly when `busOwned` is high and `tenureCount` is zero.
- R6: `mustRelease` is high exactly when `expired` is high and `gntN` is high (grant removed). It reacts to `gntN` within the same cycle.
- R7: While `gntN` is low (grant held), `mustRelease` stays low, including after expiry.
- R8: A cycle with `xferDone` high and `frameStart` low clears `busOwned` from the next cycle, whatever the count. `mustRelease` is then low.
- R9: `frameStart` during an ongoing tenure reloads `tenureCount` from `cfgLimit`. It takes priority over `xferDone` in the same cycle.
- R10: A limit write during a tenure leaves the running count unaffected. The new limit applies from the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Limit register write strobe |
| cfgWrData | input | 8 | Limit write data; bits [3:0] are ignored |
| frameStart | input | 1 | Master begins a transaction this cycle |
| gntN | input | 1 | Bus grant, active low |
| xferDone | input | 1 | Master finished its transfer this cycle |
| cfgLimit | output | 8 | Current tenure limit, low nibble fixed at ones |
| tenureCount | output | 8 | Remaining tenure clocks |
| busOwned | output | 1 | A tenure is in progress |
| expired | output | 1 | Tenure in progress with count at zero |
| mustRelease | output | 1 | Master must end its burst at the next data phase |

## Verification
The embedded assertions check the following on every cycle:
- the load of the limit on a transaction start;
- the single-step decrement;
- the hold at zero;
- the exit of ownership after a completed transfer;
- that `mustRelease` never appears while the grant is held or before expiry.

Only the directed scenarios can show the rest. These are that a written low nibble is discarded, that the exact count of clocks to expiry follows the programmed step of 16, that a write during a tenure takes effect only on the next load, and that a restart beats a same-cycle completion.

// File: rtl/tenure_pkg.sv
package tenure_pkg;
  localparam int unsigned LIMIT_W    = 8;
  localparam int unsigned FIXED_LSBS = 4;

  typedef struct packed {
    logic load;   // copy limit into counter
    logic dec;    // step counter down by one
  } tenureStrobe_t;
endpackage

// File: rtl/tenure_dp.sv
module tenure_dp
  import tenure_pkg::*;
#(
  parameter int unsigned W = LIMIT_W,
  parameter int unsigned FIXED = FIXED_LSBS
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWrEn,
  input  logic [W-1:0]  cfgWrData,
  input  tenureStrobe_t strobe,
  output logic [W-1:0]  limitOut,
  output logic [W-1:0]  countOut,
  output logic          cntZero
);
  localparam int unsigned PROG_W = W - FIXED;

  logic [PROG_W-1:0] progBits;
  logic [W-1:0]      count;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        progBits <= '0;
    else if (cfgWrEn) progBits <= cfgWrData[W-1:FIXED];
  end

  assign limitOut = {progBits, {FIXED{1'b1}}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            count <= '0;
    else if (strobe.load) count <= limitOut;
    else if (strobe.dec)  count <= count - {{(W-1){1'b0}}, 1'b1};
  end

  assign countOut = count;
  assign cntZero  = (count == '0);

  p_load_limit_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> count == $past(limitOut));

  p_step_one_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.dec && !strobe.load) |=> count == $past(count) - 1'b1);

  p_keep_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cntZero && !strobe.load) |=> cntZero);
endmodule

// File: rtl/tenure_ctrl.sv
module tenure_ctrl
  import tenure_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          frameStart,
  input  logic          xferDone,
  input  logic          gntN,
  input  logic          cntZero,
  output tenureStrobe_t strobe,
  output logic          owned,
  output logic          expiredOut,
  output logic          releaseOut
);
  typedef enum logic {ST_IDLE, ST_OWN} tenureState_e;
  tenureState_e state, stateNext;

  always_comb begin
    stateNext = state;
    if (frameStart)                     stateNext = ST_OWN;
    else if (state == ST_OWN && xferDone) stateNext = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign owned       = (state == ST_OWN);
  assign strobe.load = frameStart;
  assign strobe.dec  = owned && !cntZero && !frameStart;
  assign expiredOut  = owned && cntZero;
  assign releaseOut  = expiredOut && gntN;

  p_done_ends_r8: assert property (@(posedge clk) disable iff (!rstN)
    (owned && xferDone && !frameStart) |=> !owned);

  p_start_owns_r9: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> owned);

  p_grant_blocks_r7: assert property (@(posedge clk) disable iff (!rstN)
    !gntN |-> !releaseOut);
endmodule

// File: rtl/mst_tenure_timer.sv
module mst_tenure_timer
  import tenure_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [LIMIT_W-1:0] cfgWrData,
  input  logic               frameStart,
  input  logic               gntN,
  input  logic               xferDone,
  output logic [LIMIT_W-1:0] cfgLimit,
  output logic [LIMIT_W-1:0] tenureCount,
  output logic               busOwned,
  output logic               expired,
  output logic               mustRelease
);
  tenureStrobe_t strobe;
  logic          cntZero;

  tenure_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameStart (frameStart),
    .xferDone   (xferDone),
    .gntN       (gntN),
    .cntZero    (cntZero),
    .strobe     (strobe),
    .owned      (busOwned),
    .expiredOut (expired),
    .releaseOut (mustRelease)
  );

  tenure_dp #(.W(LIMIT_W), .FIXED(FIXED_LSBS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgWrData (cfgWrData),
    .strobe    (strobe),
    .limitOut  (cfgLimit),
    .countOut  (tenureCount),
    .cntZero   (cntZero)
  );

  p_release_needs_expiry_r6: assert property (@(posedge clk) disable iff (!rstN)
    mustRelease |-> (busOwned && tenureCount == '0 && gntN));
endmodule

// File: tb/tb_mst_tenure_timer.sv
module tb_mst_tenure_timer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [7:0] cfgWrData = 8'h00;
  logic       frameStart = 1'b0;
  logic       gntN = 1'b0;
  logic       xferDone = 1'b0;
  logic [7:0] cfgLimit, tenureCount;
  logic       busOwned, expired, mustRelease;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always #10 clk = ~clk;

  mst_tenure_timer dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .frameStart(frameStart), .gntN(gntN), .xferDone(xferDone),
    .cfgLimit(cfgLimit), .tenureCount(tenureCount), .busOwned(busOwned),
    .expired(expired), .mustRelease(mustRelease)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      nFails = nFails + 1;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // advance one edge; inputs set after this are taken at the next edge
  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic writeLimit(input logic [7:0] d);
    cfgWrEn = 1'b1; cfgWrData = d;
    step();
    cfgWrEn = 1'b0;
  endtask

  task automatic startFrame();
    frameStart = 1'b1;
    step();
    frameStart = 1'b0;
  endtask

  task automatic testReset();
    check("R1 reset limit", cfgLimit, 8'h0F);
    check("R3 reset owned", busOwned, 0);
    check("R6 reset release", mustRelease, 0);
  endtask

  task automatic testConfig();
    writeLimit(8'h35);
    check("R1 low nibble forced", cfgLimit, 8'h3F);
    check("R2 upper nibble written", cfgLimit[7:4], 4'h3);
    cfgWrData = 8'hA0;
    step();
    check("R2 no write holds", cfgLimit, 8'h3F);
    writeLimit(8'h10);
    check("R1 write zeros low", cfgLimit, 8'h1F);
  endtask

  task automatic testCountdown();
    gntN = 1'b0;
    startFrame();
    check("R3 load count", tenureCount, 8'h1F);
    check("R3 owned", busOwned, 1);
    for (int k = 1; k <= 31; k++) begin
      step();
      if (k == 10) check("R4 mid count", tenureCount, 8'h1F - 10);
    end
    check("R4 reaches zero", tenureCount, 0);
    check("R5 expired", expired, 1);
    check("R7 grant held no release", mustRelease, 0);
    step(); step();
    check("R5 holds zero", tenureCount, 0);
    check("R7 still no release", mustRelease, 0);
    gntN = 1'b1;
    #1;
    check("R6 release on grant loss", mustRelease, 1);
    xferDone = 1'b1;
    step();
    xferDone = 1'b0;
    check("R8 done clears owned", busOwned, 0);
    check("R8 release low after done", mustRelease, 0);
    gntN = 1'b0;
  endtask

  task automatic testEarlyDone();
    startFrame();
    gntN = 1'b1;
    step(); step();
    check("R6 no release before expiry", mustRelease, 0);
    check("R4 count after two", tenureCount, 8'h1D);
    xferDone = 1'b1;
    step();
    xferDone = 1'b0;
    check("R8 early done", busOwned, 0);
    gntN = 1'b0;
  endtask

  task automatic testReloadAndWrite();
    startFrame();
    step(); step(); step();
    writeLimit(8'h0C);
    check("R10 count unaffected", tenureCount, 8'h1B);
    check("R10 new limit", cfgLimit, 8'h0F);
    frameStart = 1'b1; xferDone = 1'b1;
    step();
    frameStart = 1'b0; xferDone = 1'b0;
    check("R9 reload priority owned", busOwned, 1);
    check("R9 reload value", tenureCount, 8'h0F);
    for (int k = 0; k < 15; k++) step();
    gntN = 1'b1;
    #1;
    check("R6 release small limit", mustRelease, 1);
    check("R5 expired small", expired, 1);
    xferDone = 1'b1;
    step();
    xferDone = 1'b0;
    gntN = 1'b0;
  endtask

  initial begin
    step(); step();
    rstN = 1'b1;
    step();
    testReset();
    testConfig();
    testCountdown();
    testEarlyDone();
    testReloadAndWrite();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule